// File: doc/BRIEF.md
# Successive Approximation Oscillator Trimmer

This block searches for the trim word of a local oscillator by binary search. A calibration starts with the most significant trim bit and works down to the least significant. For each bit, the block sets the bit tentatively in the trim output. It then counts cycles of its own clock, which is the oscillator being trimmed, over a fixed number of ticks from a slow, accurate reference. A single comparison of that count against a target decides whether the bit stays.

A count at or above the target means the oscillator runs fast, so the bit is dropped. Otherwise the bit is kept. The search mask shifts right after every trial, and the calibration ends when the mask shifts out. No separate loop counter is used, and no iteration is skipped, so a calibration always takes the same number of reference windows.

A watchdog catches a missing reference. If no tick arrives for a set number of cycles during a window, the block raises an error and stops until the next start.

Top module: `osc_sar_trimmer`

## Requirements
- R1: After reset, `trim_o` is all zeros and `busy_o`, `done_o` and `error_o` are low.
- R2: A `start_i` pulse accepted while not busy raises `busy_o` on the next cycle, and `trim_o` then holds only its most significant bit (0x40 for the default 7-bit trim).
- R3: A calibration runs exactly TRIM_W trials, from MSB to LSB. Each trial's window consumes exactly WINDOW_TICKS reference ticks, so one calibration consumes TRIM_W*WINDOW_TICKS ticks.
- R4: At the end of each window, the trial bit is cleared when the cycle count is at least THRESH*2^CMP_SHIFT, and kept otherwise. The count covers every clock cycle of the window, including the one on which the last tick lands.
- R5: The calibration ends when the search mask shifts out. `done_o` is then high for exactly one cycle, during which `busy_o` is already low.
- R6: After `done_o`, `trim_o` holds its final value until the next accepted start.
- R7: `start_i` asserted while `busy_o` is high has no effect on the trim sequence, the result or the number of windows.
- R8: If TIMEOUT consecutive cycles of a window pass with no reference tick, `error_o` goes high, `busy_o` drops, no `done_o` is produced and `trim_o` holds. A later start clears `error_o` and runs a normal calibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock from the oscillator being trimmed; it is also the measurement clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Requests a calibration; taken only when not busy |
| ref_tick_i | input | 1 | One-cycle pulse per reference clock tick, already synchronised to `clk` |
| trim_o | output | TRIM_W | Current trial or final trim word |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | One-cycle pulse when the calibration completes |
| error_o | output | 1 | Reference missing; stays high until the next start |

## Verification
The end of one calibration and the start of the next can fall in the same cycle: a start raised during the single cycle that `done_o` is high lands when the block is already idle. The bench provokes this by driving `start_i` on the very cycle it sees `done_o`. It then judges the result by checking three things: `busy_o` rises with the trim back at its top bit, the second search reaches the same computed result, and it consumes the full number of windows.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_MEAS  = 2'd1,
      ST_FAULT = 2'd2
   } trim_state_e;

endpackage

// File: rtl/trim_window_meter.sv
module trim_window_meter #(
   parameter int WINDOW_TICKS = 218,
   parameter int COUNT_W      = 16,
   parameter int TIMEOUT      = 4096
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               ref_tick,
   output logic               win_end,
   output logic [COUNT_W-1:0] win_count,
   output logic               stall
);

   localparam int TW = $clog2(WINDOW_TICKS + 1);
   localparam logic [TW-1:0]      LAST_TICK = TW'(WINDOW_TICKS - 1);
   localparam logic [COUNT_W-1:0] CNT_MAX   = '1;

   logic [COUNT_W-1:0] cyc_q;
   logic [TW-1:0]      tick_q;

   // count includes the current cycle; saturates instead of wrapping
   assign win_count = (cyc_q == CNT_MAX) ? CNT_MAX : cyc_q + 1'b1;
   assign win_end   = run && ref_tick && (tick_q == LAST_TICK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q  <= '0;
         tick_q <= '0;
      end else if (!run || win_end) begin
         cyc_q  <= '0;
         tick_q <= '0;
      end else begin
         cyc_q <= win_count;
         if (ref_tick) tick_q <= tick_q + 1'b1;
      end
   end

   generate
      if (TIMEOUT > 0) begin : g_watch
         localparam int SW = $clog2(TIMEOUT + 1);
         logic [SW-1:0] quiet_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                quiet_q <= '0;
            else if (!run || ref_tick) quiet_q <= '0;
            else                       quiet_q <= quiet_q + 1'b1;
         end

         assign stall = run && !ref_tick && (quiet_q == SW'(TIMEOUT - 1));

         // R8: the silence counter never runs past the limit
         p_quiet_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
            run |-> (quiet_q < SW'(TIMEOUT)));
      end else begin : g_nowatch
         assign stall = 1'b0;
      end
   endgenerate

   // R3: a window never holds more ticks than its length
   p_tick_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (tick_q <= LAST_TICK));

   // R3: after a window closes the tick tally restarts from zero
   p_window_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      win_end |=> (tick_q == '0 && cyc_q == '0));

endmodule

// File: rtl/trim_sar_ctrl.sv
module trim_sar_ctrl
   import osc_trim_pkg::*;
#(
   parameter int TRIM_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              win_end,
   input  logic              too_high,
   input  logic              stall,
   output logic [TRIM_W-1:0] trim,
   output logic              busy,
   output logic              done,
   output logic              fault
);

   localparam logic [TRIM_W-1:0] TOP_BIT = TRIM_W'(1) << (TRIM_W - 1);

   trim_state_e       state_q;
   logic [TRIM_W-1:0] mask_q;
   logic [TRIM_W-1:0] value_q;
   logic [TRIM_W-1:0] kept;
   logic [TRIM_W-1:0] next_mask;
   logic              done_q;

   always_comb begin
      kept      = too_high ? (value_q & ~mask_q) : value_q;
      next_mask = mask_q >> 1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mask_q  <= '0;
         value_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE, ST_FAULT: begin
               if (start) begin
                  state_q <= ST_MEAS;
                  mask_q  <= TOP_BIT;
                  value_q <= TOP_BIT;
               end
            end
            ST_MEAS: begin
               if (win_end) begin
                  if (next_mask == '0) begin
                     value_q <= kept;
                     mask_q  <= '0;
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     value_q <= kept | next_mask;
                     mask_q  <= next_mask;
                  end
               end else if (stall) begin
                  state_q <= ST_FAULT;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign trim  = value_q;
   assign busy  = (state_q == ST_MEAS);
   assign done  = done_q;
   assign fault = (state_q == ST_FAULT);

   // R3: at most one trial bit is in flight
   p_mask_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mask_q));

   // R4: a fast window removes the bit under test
   p_clear_on_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && win_end && too_high) |=> ((value_q & $past(mask_q)) == '0));

   // R4: a slow window keeps the bit under test
   p_keep_on_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && win_end && !too_high) |=> ((value_q & $past(mask_q)) != '0));

   // R5: completion is a single-cycle pulse outside the busy phase
   p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_not_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R6: when idle or faulted and not restarted, the trim word holds
   p_trim_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(trim));

   // R7: a start during a window does not end the search
   p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !win_end && !stall) |=> (busy && $stable(trim)));

   // R8: the fault state persists until restarted
   p_fault_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fault && !start) |=> (fault && !done));

endmodule

// File: rtl/osc_sar_trimmer.sv
module osc_sar_trimmer #(
   parameter int TRIM_W       = 7,
   parameter int WINDOW_TICKS = 218,
   parameter int COUNT_W      = 16,
   parameter int CMP_SHIFT    = 8,
   parameter int THRESH       = 26,
   parameter int TIMEOUT      = 4096
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              ref_tick_i,
   output logic [TRIM_W-1:0] trim_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              error_o
);

   // full-width limit equivalent to comparing only the upper count bits
   localparam logic [COUNT_W:0] LIMIT = (COUNT_W + 1)'(THRESH) << CMP_SHIFT;

   initial begin
      assert (TRIM_W >= 1) else $error("TRIM_W must be at least 1");
      assert (WINDOW_TICKS >= 1) else $error("WINDOW_TICKS must be at least 1");
      assert (CMP_SHIFT < COUNT_W) else $error("CMP_SHIFT must be below COUNT_W");
      assert (THRESH > 0 && THRESH < (1 << (COUNT_W - CMP_SHIFT)))
         else $error("THRESH does not fit the compared count bits");
      assert (TIMEOUT >= 0) else $error("TIMEOUT must not be negative");
   end

   logic               win_end;
   logic [COUNT_W-1:0] win_count;
   logic               stall;
   logic               too_high;
   logic               busy;

   trim_window_meter #(
      .WINDOW_TICKS (WINDOW_TICKS),
      .COUNT_W      (COUNT_W),
      .TIMEOUT      (TIMEOUT)
   ) u_meter (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (busy),
      .ref_tick  (ref_tick_i),
      .win_end   (win_end),
      .win_count (win_count),
      .stall     (stall)
   );

   assign too_high = ({1'b0, win_count} >= LIMIT);

   trim_sar_ctrl #(
      .TRIM_W (TRIM_W)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start_i),
      .win_end  (win_end),
      .too_high (too_high),
      .stall    (stall),
      .trim     (trim_o),
      .busy     (busy),
      .done     (done_o),
      .fault    (error_o)
   );

   assign busy_o = busy;

   // R8: an error never coincides with completion or activity
   p_error_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      error_o |-> (!done_o && !busy_o));

   // R2: an accepted start opens a window on the next cycle
   p_start_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

endmodule

// File: tb/test_osc_sar_trimmer.sv
module test_osc_sar_trimmer;

   localparam int CLK_PERIOD = 10;
   localparam int TW   = 7;
   localparam int WIN  = 16;
   localparam int CW   = 16;
   localparam int SH   = 3;
   localparam int TH   = 51;   // limit 408: period 25 gives ~401, period 26 gives ~417
   localparam int TO   = 64;
   localparam int FAST_PERIOD = 26;
   localparam int MAX_CYC = 190000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b1;
   logic          start_i = 1'b0;
   logic          ref_tick_i = 1'b0;
   logic [TW-1:0] trim_o;
   logic          busy_o, done_o, error_o;

   osc_sar_trimmer #(
      .TRIM_W(TW), .WINDOW_TICKS(WIN), .COUNT_W(CW),
      .CMP_SHIFT(SH), .THRESH(TH), .TIMEOUT(TO)
   ) i_osc_sar_trimmer (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .ref_tick_i(ref_tick_i),
      .trim_o(trim_o), .busy_o(busy_o), .done_o(done_o), .error_o(error_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int tests = 0;
   int fails = 0;
   int base_g = 14;
   bit tick_en = 1'b0;
   int tick_cnt = 0;
   int ticks_seen = 0;
   int done_seen = 0;
   int cycles = 0;
   logic [TW-1:0] last_trim = '0;

   task automatic summary_and_end();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   // Oscillator model: reference tick period in fast cycles grows with the trim.
   always @(negedge clk) begin : osc_model
      int per;
      per = base_g + int'(trim_o) / 8;
      cycles++;
      if (done_o) done_seen++;
      if (!tick_en || trim_o != last_trim) begin
         tick_cnt = 0;
         ref_tick_i <= 1'b0;
      end else begin
         tick_cnt++;
         if (tick_cnt >= per) begin
            tick_cnt = 0;
            ref_tick_i <= 1'b1;
            if (busy_o) ticks_seen++;
         end else begin
            ref_tick_i <= 1'b0;
         end
      end
      last_trim = trim_o;
      if (cycles > MAX_CYC) begin
         tests++;
         fails++;
         $display("FAIL watchdog actual=%0d expected<=%0d", cycles, MAX_CYC);
         summary_and_end();
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Expected search result: keep each bit unless its period reaches the fast limit.
   function automatic int exp_trim(input int base);
      int v = 0;
      for (int b = TW - 1; b >= 0; b--) begin
         int cand = v | (1 << b);
         if (base + cand / 8 < FAST_PERIOD) v = cand;
      end
      return v;
   endfunction

   task automatic wait_done();
      int guard = 0;
      while (done_o !== 1'b1 && guard < 20000) begin
         @(negedge clk);
         guard++;
      end
   endtask

   task automatic run_cal(input int base, input bit poke);
      int guard;
      int exp;
      exp = exp_trim(base);
      base_g = base;
      tick_en = 1'b1;
      @(negedge clk);
      start_i = 1'b1;
      ticks_seen = 0;
      done_seen = 0;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o === 1'b1 && trim_o === 7'h40, "R2 busy and top trial bit", int'(trim_o), 64);
      guard = 0;
      while (done_o !== 1'b1 && guard < 20000) begin
         @(negedge clk);
         guard++;
         start_i = (poke && guard == 200);
      end
      start_i = 1'b0;
      chk(done_o === 1'b1, "R5 done reached", int'(done_o), 1);
      chk(int'(trim_o) == exp, "R4 final trim", int'(trim_o), exp);
      chk(ticks_seen == TW * WIN, "R3 ticks per calibration", ticks_seen, TW * WIN);
      chk(busy_o === 1'b0, "R5 busy low with done", int'(busy_o), 0);
      if (poke) chk(ticks_seen == TW * WIN && int'(trim_o) == exp,
                    "R7 start during run ignored", int'(trim_o), exp);
      @(negedge clk);
      chk(done_o === 1'b0 && done_seen == 1, "R5 single done pulse", done_seen, 1);
      repeat (20) @(negedge clk);
      chk(int'(trim_o) == exp && !busy_o, "R6 trim holds after done", int'(trim_o), exp);
   endtask

   initial begin
      int exp;
      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(trim_o === '0 && busy_o === 1'b0 && done_o === 1'b0 && error_o === 1'b0,
          "R1 reset state", int'(trim_o), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed: mid-range, extremes, threshold edge
      run_cal(14, 1'b0);
      run_cal(8, 1'b0);    // always slow: every bit kept
      run_cal(30, 1'b0);   // always fast: every bit dropped
      run_cal(25, 1'b0);   // boundary just above the lowest bits

      // constrained random
      void'($urandom(32'h1F2E));
      for (int i = 0; i < 6; i++) run_cal(int'($urandom_range(28, 10)), 1'b0);

      // R7: start pulse in the middle of a calibration
      run_cal(18, 1'b1);

      // R5/R2: new start in the same cycle as done
      base_g = 20;
      exp = exp_trim(20);
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      wait_done();
      chk(done_o === 1'b1 && int'(trim_o) == exp, "R5 first of chained pair", int'(trim_o), exp);
      start_i = 1'b1;
      ticks_seen = 0;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o === 1'b1 && trim_o === 7'h40, "R2 start taken during done cycle", int'(trim_o), 64);
      wait_done();
      chk(int'(trim_o) == exp && ticks_seen == TW * WIN, "R3 chained calibration complete",
          ticks_seen, TW * WIN);
      repeat (5) @(negedge clk);

      // R8: missing reference
      tick_en = 1'b0;
      done_seen = 0;
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (TO + 4) @(negedge clk);
      chk(error_o === 1'b1 && busy_o === 1'b0, "R8 error on silent reference", int'(error_o), 1);
      chk(trim_o === 7'h40 && done_seen == 0, "R8 trim holds, no done", int'(trim_o), 64);
      repeat (10) @(negedge clk);
      chk(error_o === 1'b1 && trim_o === 7'h40, "R8 error persists", int'(error_o), 1);
      run_cal(14, 1'b0);
      chk(error_o === 1'b0, "R8 restart clears error", int'(error_o), 0);

      summary_and_end();
   end

endmodule